// File: doc/BRIEF.md
# SPI Serial Clock Generator with Selectable Data Edges

This block derives an SPI serial clock from a fast reference clock. It does not count to an integer divisor. It adds a programmable increment into a 12-bit phase accumulator on every reference cycle, and each carry out of the accumulator toggles the serial clock. The same carry tells the data shifter when to act. On every transition the block raises either a one-cycle launch strobe (drive the next output bit) or a one-cycle sample strobe (capture the incoming bit), depending on whether that transition is a rising or a falling one.

Software programs a 16-bit increment word. Its largest meaningful value, 2048, gives the fastest clock: one toggle every two reference cycles. Larger words are held at 2048. A mode bit chooses how a wrap is handled. The accumulator can either carry its remainder forward, which averages the requested fractional rate, or restart from zero, which gives an even period rounded down in frequency. Two select bits name the serial-clock direction used for launching and the one used for sampling. A polarity bit sets the idle level. A flag tells the input stage that the programmed rate is high enough to need its alternate capture path.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sclk` equals `cpol`, both strobes are low, and the accumulator holds zero.
- R2: With `run_en` high, the effective increment is added to the accumulator every reference cycle. Every carry past 4095 toggles `sclk` in the following output cycle. An increment of 2048 toggles `sclk` every 2 cycles, and 1024 toggles it every 4 cycles.
- R3: A `freq_word` above 2048 behaves exactly like 2048. A `freq_word` of 0 never toggles `sclk`.
- R4: With `wrap_clear` low, the remainder past 4096 is kept across a wrap (increment 1365 gives 9 toggles in 30 cycles). With `wrap_clear` high, the accumulator restarts at 0 on a wrap (increment 1365 gives 7 toggles in 30 cycles).
- R5: With `run_en` low, the accumulator is cleared, `sclk` returns to `cpol` one cycle later, and both strobes stay low. After `run_en` rises, the first toggle appears after ceil(4096/increment) cycles.
- R6: `sclk` equals the internal phase XOR `cpol`, so `cpol`=1 idles the clock high. Rising and falling in R7 to R9 refer to `sclk` as seen at the port.
- R7: `launch_stb` is high for exactly one cycle, in the same cycle as an `sclk` transition in the direction named by `launch_rise` (1 = rising, 0 = falling).
- R8: `sample_stb` is high for exactly one cycle, in the same cycle as an `sclk` transition in the direction named by `sample_rise` (1 = rising, 0 = falling).
- R9: When `launch_rise` equals `sample_rise`, only `sample_stb` fires on those transitions. The two strobes are never high in the same cycle.
- R10: `fast_path` is high exactly when the effective increment is at least `FAST_INC` (default 1024).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enables accumulation; low parks the clock at idle |
| freq_word | input | 16 | Phase increment, saturated at 2048 |
| wrap_clear | input | 1 | 1 = restart accumulator at 0 on wrap |
| launch_rise | input | 1 | 1 = launch on rising `sclk`, 0 = on falling |
| sample_rise | input | 1 | 1 = sample on rising `sclk`, 0 = on falling |
| cpol | input | 1 | Idle level of `sclk` |
| sclk | output | 1 | SPI serial clock |
| launch_stb | output | 1 | One-cycle pulse: shift out next bit |
| sample_stb | output | 1 | One-cycle pulse: capture input bit |
| fast_path | output | 1 | Programmed rate needs the alternate capture path |

## Verification
Launch and sample are the two functions that can land in the same cycle, which happens when both selects name the same clock direction. The bench provokes this by setting `launch_rise` equal to `sample_rise` at full and fractional rates and with both polarities. On every cycle it compares the strobes with a cycle model built from the requirements. The model expects only the sample pulse on each matching transition, and it expects the launch pulse to be absent.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

    // registered state of the edge stage
    typedef struct packed {
        logic phase;
        logic launch;
        logic sample;
    } edge_state_t;

endpackage

// File: rtl/spiclk_accum.sv
module spiclk_accum #(
    parameter int ACC_W    = 12,
    parameter int INC_W    = 16,
    parameter int FULL_INC = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [INC_W-1:0] freq_word,
    input  logic             wrap_clear,
    output logic             carry_o,
    output logic [ACC_W-1:0] eff_inc_o
);
    localparam int SUM_W = ACC_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t       st_d, st_q;
    logic [SUM_W-1:0] sum;
    logic [ACC_W-1:0] eff_inc;

    always_comb begin
        if (freq_word > INC_W'(FULL_INC)) eff_inc = ACC_W'(FULL_INC);
        else                              eff_inc = freq_word[ACC_W-1:0];
        sum      = {1'b0, st_q.acc} + {1'b0, eff_inc};
        carry_o  = run_en & sum[ACC_W];
        st_d     = st_q;
        if (!run_en)                      st_d.acc = '0;
        else if (carry_o && wrap_clear)   st_d.acc = '0;
        else                              st_d.acc = sum[ACC_W-1:0];
    end

    assign eff_inc_o = eff_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    acc_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> st_q.acc == '0);

    // R3
    acc_below_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> st_q.acc >= ACC_W'((1 << ACC_W) - FULL_INC));

endmodule

// File: rtl/spiclk_edge.sv
module spiclk_edge
    import spiclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic carry,
    input  logic cpol,
    input  logic launch_rise,
    input  logic sample_rise,
    output logic phase_o,
    output logic launch_o,
    output logic sample_o
);
    edge_state_t st_d, st_q;
    logic        pin_next;
    logic        same_dir;

    always_comb begin
        st_d     = st_q;
        same_dir = (launch_rise == sample_rise);
        if (!run_en) begin
            st_d = '0;
            pin_next = cpol;
        end else begin
            st_d.phase  = st_q.phase ^ carry;
            pin_next    = st_d.phase ^ cpol;
            st_d.sample = carry & (pin_next == sample_rise);
            st_d.launch = carry & (pin_next == launch_rise) & ~same_dir;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o  = st_q.phase;
    assign launch_o = st_q.launch;
    assign sample_o = st_q.sample;

    // R9
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.launch && st_q.sample));

    // R7
    launch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.launch |=> !st_q.launch);

    // R7
    launch_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.launch |-> st_q.phase != $past(st_q.phase));

    // R8
    sample_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sample |-> st_q.phase != $past(st_q.phase));

    // R5
    idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!st_q.phase && !st_q.launch && !st_q.sample));

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
    parameter int ACC_W    = 12,
    parameter int INC_W    = 16,
    parameter int FULL_INC = 2048,
    parameter int FAST_INC = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [INC_W-1:0] freq_word,
    input  logic             wrap_clear,
    input  logic             launch_rise,
    input  logic             sample_rise,
    input  logic             cpol,
    output logic             sclk,
    output logic             launch_stb,
    output logic             sample_stb,
    output logic             fast_path
);
    logic             carry;
    logic             phase;
    logic [ACC_W-1:0] eff_inc;

    spiclk_accum #(
        .ACC_W    (ACC_W),
        .INC_W    (INC_W),
        .FULL_INC (FULL_INC)
    ) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .freq_word  (freq_word),
        .wrap_clear (wrap_clear),
        .carry_o    (carry),
        .eff_inc_o  (eff_inc)
    );

    spiclk_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .carry       (carry),
        .cpol        (cpol),
        .launch_rise (launch_rise),
        .sample_rise (sample_rise),
        .phase_o     (phase),
        .launch_o    (launch_stb),
        .sample_o    (sample_stb)
    );

    assign sclk      = phase ^ cpol;
    assign fast_path = (eff_inc >= ACC_W'(FAST_INC));

    // R10
    fast_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_path |-> freq_word >= INC_W'(FAST_INC));

    // R8
    sample_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && $stable(cpol)) |-> sclk == sample_rise);

    // R7
    launch_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_stb && $stable(cpol)) |-> sclk == launch_rise);

endmodule

// File: tb/tb_spi_sclk_gen.sv
`timescale 1ns/1ps
module tb_spi_sclk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [15:0] freq_word = 16'd0;
    logic        wrap_clear = 1'b0;
    logic        launch_rise = 1'b1;
    logic        sample_rise = 1'b0;
    logic        cpol = 1'b0;
    logic        sclk, launch_stb, sample_stb, fast_path;

    int vectors = 0;
    int fails = 0;
    int m_acc = 0;
    int m_ph = 0;
    int toggles = 0;
    int first_at = 0;

    always #10 clk = ~clk;

    spi_sclk_gen dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .freq_word(freq_word),
        .wrap_clear(wrap_clear), .launch_rise(launch_rise),
        .sample_rise(sample_rise), .cpol(cpol), .sclk(sclk),
        .launch_stb(launch_stb), .sample_stb(sample_stb), .fast_path(fast_path)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // one reference cycle: advance the requirement model, compare ports
    task automatic cyc(input string req);
        int inc;
        bit tog;
        int pin;
        bit el, es;
        @(negedge clk);
        tog = 1'b0;
        inc = (freq_word > 16'd2048) ? 2048 : int'(freq_word);
        if (!rst_n || !run_en) begin
            m_acc = 0;
            m_ph  = 0;
        end else begin
            m_acc += inc;
            if (m_acc >= 4096) begin
                tog  = 1'b1;
                m_ph = 1 - m_ph;
                m_acc = wrap_clear ? 0 : m_acc - 4096;
            end
        end
        pin = m_ph ^ int'(cpol);
        es = tog && (pin == int'(sample_rise));
        el = tog && (pin == int'(launch_rise)) && (launch_rise != sample_rise);
        if (tog) begin
            toggles++;
            if (first_at == 0) first_at = 1;
        end
        chk(sclk == pin[0], req, "sclk", int'(sclk), pin);
        chk(launch_stb == el, req, "launch_stb", int'(launch_stb), int'(el));
        chk(sample_stb == es, req, "sample_stb", int'(sample_stb), int'(es));
    endtask

    task automatic run_n(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(req);
    endtask

    task automatic t_reset();
        cyc("R1");
        cyc("R1");
        rst_n = 1'b1;
        cyc("R1");
        chk(!sclk && !launch_stb && !sample_stb, "R1", "idle after reset", int'(sclk), 0);
    endtask

    task automatic t_full_rate();
        freq_word = 16'd2048; run_en = 1'b1;
        run_n(20, "R2");
        freq_word = 16'd1024;
        run_n(24, "R2");
        run_en = 1'b0; cyc("R5");
    endtask

    task automatic t_saturate();
        freq_word = 16'hFFFF; run_en = 1'b1;
        toggles = 0;
        run_n(20, "R3");
        chk(toggles == 10, "R3", "toggles at saturated word", toggles, 10);
        run_en = 1'b0; cyc("R5");
        freq_word = 16'd0; run_en = 1'b1;
        toggles = 0;
        run_n(40, "R3");
        chk(toggles == 0, "R3", "toggles at zero word", toggles, 0);
        run_en = 1'b0; cyc("R5");
    endtask

    task automatic t_fractional();
        freq_word = 16'd1365; wrap_clear = 1'b0; run_en = 1'b1;
        toggles = 0;
        run_n(30, "R4");
        chk(toggles == 9, "R4", "carry-forward toggles", toggles, 9);
        run_en = 1'b0; cyc("R5");
        wrap_clear = 1'b1; run_en = 1'b1;
        toggles = 0;
        run_n(30, "R4");
        chk(toggles == 7, "R4", "restart-on-wrap toggles", toggles, 7);
        run_en = 1'b0; cyc("R5"); wrap_clear = 1'b0;
    endtask

    task automatic t_run_gate();
        int k;
        freq_word = 16'd1000; run_en = 1'b1;
        run_n(7, "R5");
        run_en = 1'b0;
        cyc("R5");
        chk(sclk == cpol, "R5", "sclk parked", int'(sclk), int'(cpol));
        run_n(3, "R5");
        run_en = 1'b1;
        k = 0; toggles = 0;
        while (toggles == 0 && k < 20) begin
            cyc("R5");
            k++;
        end
        chk(k == 5, "R5", "first toggle cycle", k, 5);
        run_en = 1'b0; cyc("R5");
    endtask

    task automatic t_polarity_edges();
        for (int p = 0; p < 2; p++) begin
            cpol = p[0]; cyc("R6");
            chk(sclk == cpol, "R6", "idle level", int'(sclk), p);
            launch_rise = 1'b1; sample_rise = 1'b0;
            freq_word = 16'd2048; run_en = 1'b1;
            run_n(12, "R7");
            run_en = 1'b0; cyc("R8");
            launch_rise = 1'b0; sample_rise = 1'b1;
            freq_word = 16'd900; run_en = 1'b1;
            run_n(30, "R8");
            run_en = 1'b0; cyc("R6");
        end
        cpol = 1'b0;
    endtask

    task automatic t_same_edge();
        int both;
        both = 0;
        for (int p = 0; p < 2; p++) begin
            cpol = p[0];
            launch_rise = p[0]; sample_rise = p[0];
            freq_word = 16'd2048; run_en = 1'b1;
            for (int i = 0; i < 16; i++) begin
                cyc("R9");
                if (launch_stb && sample_stb) both++;
            end
            freq_word = 16'd1500;
            run_n(20, "R9");
            run_en = 1'b0; cyc("R9");
        end
        chk(both == 0, "R9", "coincident strobes", both, 0);
        cpol = 1'b0; launch_rise = 1'b1; sample_rise = 1'b0;
    endtask

    task automatic t_fast_flag();
        freq_word = 16'd1023; #1;
        chk(fast_path == 1'b0, "R10", "flag at 1023", int'(fast_path), 0);
        freq_word = 16'd1024; #1;
        chk(fast_path == 1'b1, "R10", "flag at 1024", int'(fast_path), 1);
        freq_word = 16'd40000; #1;
        chk(fast_path == 1'b1, "R10", "flag at saturated word", int'(fast_path), 1);
        freq_word = 16'd0; #1;
        chk(fast_path == 1'b0, "R10", "flag at zero", int'(fast_path), 0);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_full_rate();
        t_saturate();
        t_fractional();
        t_run_gate();
        t_polarity_edges();
        t_same_edge();
        t_fast_flag();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule